// File: doc/BRIEF.md
# ISA I/O Slave Front End with Byte-Lane Steering

This block sits between a 16-bit ISA I/O bus and the register file and word FIFO of a peripheral that owns a 32-byte window of I/O space. The upper five address bits are compared with five strap inputs, and the window is claimed only while the address-enable input is low. The low five address bits pick the register. The byte-high enable and the bus-width sense input pick which byte lane carries the data.

Reads are combinational while the read strobe is low. Writes are captured while the write strobe is low and handed to the register side as a one-clock pulse after the strobe rises. A FIFO word access at offset 24 carries FIFO A on the upper lane and FIFO B on the lower lane. Two open-collector pull-down requests come out of the block. The first marks a 16-bit (upper-lane) access. The second stretches the host cycle while the FIFO cannot serve it.

Top module: `isa_slave_front`

## Requirements
- R1: The block is selected only when `aen_n` is low and `sa[9:5]` equals `base_strap`; strap value 5'b10110 places the window at 10'h2C0. When not selected, no lane is driven, no write or pop pulse is issued and `iocs16_pull` stays low.
- R2: With `sense16_n` high (8-bit bus) and `sbhe_n` high, every offset uses the lower lane only; the upper lane is never driven and `dhi_in` is never used.
- R3: With `sense16_n` low, an odd offset with `sbhe_n` low uses the upper lane only.
- R4: With `sense16_n` low, an even offset with `sbhe_n` high uses the lower lane only, offset 5'b11000 included.
- R5: With `sense16_n` low, `sbhe_n` low and offset 5'b11000, the access is a FIFO word: the upper lane carries bits 15:8 (FIFO A) and the lower lane bits 7:0 (FIFO B) of `fifo_rdata`/`fifo_wdata`.
- R6: All other combinations are illegal: 8-bit bus with `sbhe_n` low, 16-bit odd offset with `sbhe_n` high, and 16-bit even offset other than 5'b11000 with `sbhe_n` low. Neither lane is driven and writes are dropped.
- R7: A register write produces `reg_wr` for exactly one clock, in the clock after `iow_n` is sampled high following a low sample. `reg_wr_off` holds the offset. `reg_wdata` holds the upper-lane byte for an upper-lane access and the lower-lane byte otherwise.
- R8: While `ior_n` is low, the selected lanes are driven without clock delay. `reg_off` follows `sa[4:0]`, and a register read drives `reg_rdata` on the active lane.
- R9: Completion of a FIFO word read gives a one-clock `fifo_pop`. Completion of a FIFO word write gives a one-clock `fifo_push` with `fifo_wdata` = {upper byte, lower byte}. The timing is the same as R7.
- R10: `iocs16_pull` is high while a strobe is low on a selected upper-lane or FIFO-word access.
- R11: `chrdy_pull` rises in the clock after a FIFO word read starts with `fifo_empty` high, or a FIFO word write starts with `fifo_full` high. It drops in the clock after the blocking flag clears, after both strobes are high, or after 64 clocks (`WAIT_MAX`), whichever comes first. Register accesses never raise it.
- R12: While `rst` is high, no lane is driven, all pulses and both pull requests are low at once, and the wait state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Asynchronous active-high reset, holds the idle state |
| sa | input | 10 | ISA I/O address |
| aen_n | input | 1 | Address enable, low qualifies a selection |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| sbhe_n | input | 1 | Byte-high enable, active low |
| sense16_n | input | 1 | Low on a 16-bit bus, high on an 8-bit bus |
| base_strap | input | 5 | Base-address straps compared with sa[9:5] |
| dlo_in | input | 8 | Lower-lane write data |
| dhi_in | input | 8 | Upper-lane write data |
| dlo_out | output | 8 | Lower-lane read data |
| dlo_oe | output | 1 | Lower-lane output enable |
| dhi_out | output | 8 | Upper-lane read data |
| dhi_oe | output | 1 | Upper-lane output enable |
| iocs16_pull | output | 1 | Request to pull the 16-bit I/O line low |
| chrdy_pull | output | 1 | Request to pull channel-ready low |
| reg_off | output | 5 | Register offset for the read mux |
| reg_rdata | input | 8 | Read data of the addressed register |
| reg_wr | output | 1 | One-clock register write pulse |
| reg_wr_off | output | 5 | Offset of the register write |
| reg_wdata | output | 8 | Data of the register write |
| fifo_rdata | input | 16 | Head FIFO word, A in 15:8, B in 7:0 |
| fifo_empty | input | 1 | FIFO has no word to read |
| fifo_full | input | 1 | FIFO has no room for a word |
| fifo_pop | output | 1 | One-clock pop after a FIFO word read |
| fifo_push | output | 1 | One-clock push after a FIFO word write |
| fifo_wdata | output | 16 | Word to push |

## Verification
The hardest case to reach from the ports is the 64-clock wait limit. It only appears when a FIFO word read begins against an empty FIFO and the host then keeps its strobe low past the limit. The bench holds `fifo_empty` high and `ior_n` low at offset 24 with the high byte enabled, then counts the clocks during which `chrdy_pull` stays up. Releases by the flag clearing, by the strobe rising and by reset are each reached in separate short scenarios. The lane map is swept over every offset, both byte-high settings and both bus widths, for reads and for writes.

// File: rtl/isa_fe_pkg.sv
package isa_fe_pkg;
  localparam int OFF_W  = 5;
  localparam int BASE_W = 5;
  localparam int ADDR_W = OFF_W + BASE_W;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [OFF_W-1:0] WORD_OFF = 5'b11000;

  typedef enum logic [1:0] {LN_NONE, LN_LO, LN_HI, LN_WORD} lane_e;

  // Lane choice from bus width, byte-high enable and offset.
  function automatic lane_e lane_of(input logic wide, input logic hi_en,
                                    input logic [OFF_W-1:0] off);
    if (!wide)                     return hi_en ? LN_NONE : LN_LO;
    if (hi_en && off == WORD_OFF)  return LN_WORD;
    if (hi_en && off[0])           return LN_HI;
    if (!hi_en && !off[0])         return LN_LO;
    return LN_NONE;
  endfunction

  function automatic logic uses_lo(input lane_e l);
    return (l == LN_LO) || (l == LN_WORD);
  endfunction

  function automatic logic uses_hi(input lane_e l);
    return (l == LN_HI) || (l == LN_WORD);
  endfunction
endpackage

// File: rtl/isa_fe_decode.sv
module isa_fe_decode
  import isa_fe_pkg::*;
(
  input  logic              rst,
  input  logic [ADDR_W-1:0] sa,
  input  logic              aen_n,
  input  logic              sbhe_n,
  input  logic              sense16_n,
  input  logic [BASE_W-1:0] strap,
  output logic              sel,
  output lane_e             lane
);
  assign sel  = !rst && !aen_n && (sa[ADDR_W-1:OFF_W] == strap);
  assign lane = sel ? lane_of(!sense16_n, !sbhe_n, sa[OFF_W-1:0]) : LN_NONE;
endmodule

// File: rtl/isa_fe_strobe.sv
module isa_fe_strobe
  import isa_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ior_n,
  input  logic              iow_n,
  input  lane_e             lane,
  input  logic [OFF_W-1:0]  off,
  input  logic [BYTE_W-1:0] dlo_in,
  input  logic [BYTE_W-1:0] dhi_in,
  output logic              rd_fall,
  output logic              wr_fall,
  output logic              reg_wr,
  output logic [OFF_W-1:0]  reg_wr_off,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              fifo_push,
  output logic [WORD_W-1:0] fifo_wdata,
  output logic              fifo_pop
);
  logic ior_q, iow_q, rd_rise, wr_rise, rcap_word;
  lane_e wcap_lane;
  logic [OFF_W-1:0]  wcap_off;
  logic [BYTE_W-1:0] wcap_lo, wcap_hi;

  assign rd_fall = ior_q && !ior_n;
  assign wr_fall = iow_q && !iow_n;
  assign rd_rise = !ior_q && ior_n;
  assign wr_rise = !iow_q && iow_n;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ior_q      <= 1'b1;
      iow_q      <= 1'b1;
      wcap_lane  <= LN_NONE;
      wcap_off   <= '0;
      wcap_lo    <= '0;
      wcap_hi    <= '0;
      rcap_word  <= 1'b0;
      reg_wr     <= 1'b0;
      fifo_push  <= 1'b0;
      fifo_pop   <= 1'b0;
      reg_wr_off <= '0;
      reg_wdata  <= '0;
      fifo_wdata <= '0;
    end else begin
      ior_q <= ior_n;
      iow_q <= iow_n;
      if (!iow_n) begin
        wcap_lane <= lane;
        wcap_off  <= off;
        wcap_lo   <= dlo_in;
        wcap_hi   <= dhi_in;
      end
      if (!ior_n) rcap_word <= (lane == LN_WORD);
      reg_wr    <= wr_rise && (wcap_lane == LN_LO || wcap_lane == LN_HI);
      fifo_push <= wr_rise && (wcap_lane == LN_WORD);
      fifo_pop  <= rd_rise && rcap_word;
      if (wr_rise) begin
        reg_wr_off <= wcap_off;
        reg_wdata  <= (wcap_lane == LN_HI) ? wcap_hi : wcap_lo;
        fifo_wdata <= {wcap_hi, wcap_lo};
      end
    end
  end

  a_r7_wr_one_clock: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);
  a_r9_pop_one_clock: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop);
  a_r9_push_one_clock: assert property (@(posedge clk) disable iff (rst)
    fifo_push |=> !fifo_push);
endmodule

// File: rtl/isa_fe_wait.sv
module isa_fe_wait #(
  parameter int WAIT_MAX = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_fall,
  input  logic wr_fall,
  input  logic word,
  input  logic fifo_empty,
  input  logic fifo_full,
  input  logic ior_n,
  input  logic iow_n,
  output logic pull
);
  localparam int CNT_W = (WAIT_MAX > 1) ? $clog2(WAIT_MAX) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_MAX - 1);

  logic waiting, for_rd, start_rd, start_wr, cleared, idle_bus, expired;
  logic [CNT_W-1:0] cnt;

  assign start_rd = rd_fall && word && fifo_empty;
  assign start_wr = wr_fall && word && fifo_full;
  assign cleared  = for_rd ? !fifo_empty : !fifo_full;
  assign idle_bus = ior_n && iow_n;
  assign expired  = (cnt == LAST);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      waiting <= 1'b0;
      for_rd  <= 1'b0;
      cnt     <= '0;
    end else if (!waiting) begin
      if (start_rd || start_wr) begin
        waiting <= 1'b1;
        for_rd  <= start_rd;
        cnt     <= '0;
      end
    end else if (cleared || idle_bus || expired) begin
      waiting <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign pull = waiting;

  a_r11_release_when_idle: assert property (@(posedge clk) disable iff (rst)
    idle_bus |=> !pull);
  a_r11_blocked_read_waits: assert property (@(posedge clk) disable iff (rst)
    (start_rd && !waiting) |=> pull);
endmodule

// File: rtl/isa_slave_front.sv
module isa_slave_front
  import isa_fe_pkg::*;
#(
  parameter int WAIT_MAX = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [9:0]  sa,
  input  logic        aen_n,
  input  logic        ior_n,
  input  logic        iow_n,
  input  logic        sbhe_n,
  input  logic        sense16_n,
  input  logic [4:0]  base_strap,
  input  logic [7:0]  dlo_in,
  input  logic [7:0]  dhi_in,
  output logic [7:0]  dlo_out,
  output logic        dlo_oe,
  output logic [7:0]  dhi_out,
  output logic        dhi_oe,
  output logic        iocs16_pull,
  output logic        chrdy_pull,
  output logic [4:0]  reg_off,
  input  logic [7:0]  reg_rdata,
  output logic        reg_wr,
  output logic [4:0]  reg_wr_off,
  output logic [7:0]  reg_wdata,
  input  logic [15:0] fifo_rdata,
  input  logic        fifo_empty,
  input  logic        fifo_full,
  output logic        fifo_pop,
  output logic        fifo_push,
  output logic [15:0] fifo_wdata
);
  logic  sel, rd_fall, wr_fall;
  lane_e lane;

  isa_fe_decode u_decode (
    .rst(rst), .sa(sa), .aen_n(aen_n), .sbhe_n(sbhe_n),
    .sense16_n(sense16_n), .strap(base_strap), .sel(sel), .lane(lane)
  );

  isa_fe_strobe u_strobe (
    .clk(clk), .rst(rst), .ior_n(ior_n), .iow_n(iow_n), .lane(lane),
    .off(sa[OFF_W-1:0]), .dlo_in(dlo_in), .dhi_in(dhi_in),
    .rd_fall(rd_fall), .wr_fall(wr_fall), .reg_wr(reg_wr),
    .reg_wr_off(reg_wr_off), .reg_wdata(reg_wdata), .fifo_push(fifo_push),
    .fifo_wdata(fifo_wdata), .fifo_pop(fifo_pop)
  );

  isa_fe_wait #(.WAIT_MAX(WAIT_MAX)) u_wait (
    .clk(clk), .rst(rst), .rd_fall(rd_fall), .wr_fall(wr_fall),
    .word(lane == LN_WORD), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .ior_n(ior_n), .iow_n(iow_n), .pull(chrdy_pull)
  );

  assign reg_off     = sa[OFF_W-1:0];
  assign dlo_oe      = !ior_n && uses_lo(lane);
  assign dhi_oe      = !ior_n && uses_hi(lane);
  assign dlo_out     = (lane == LN_WORD) ? fifo_rdata[BYTE_W-1:0] : reg_rdata;
  assign dhi_out     = (lane == LN_WORD) ? fifo_rdata[WORD_W-1:BYTE_W] : reg_rdata;
  assign iocs16_pull = (!ior_n || !iow_n) && uses_hi(lane);

  a_r1_drive_needs_match: assert property (@(posedge clk) disable iff (rst)
    (dlo_oe || dhi_oe) |-> (!aen_n && sa[9:5] == base_strap));
  a_r2_narrow_bus_no_upper: assert property (@(posedge clk) disable iff (rst)
    sense16_n |-> (!dhi_oe && !iocs16_pull));
  a_r12_reset_quiet: assert property (@(posedge clk)
    rst |-> (!dlo_oe && !dhi_oe && !chrdy_pull && !reg_wr && !fifo_pop));
endmodule

// File: tb/isa_slave_front_bench.sv
`timescale 1ns/1ps
module isa_slave_front_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic [9:0] sa = 10'h2C0;
  logic aen_n = 1'b0, ior_n = 1'b1, iow_n = 1'b1, sbhe_n = 1'b1, sense16_n = 1'b0;
  logic [4:0] base_strap = 5'b10110;
  logic [7:0] dlo_in = '0, dhi_in = '0, reg_rdata = 8'h5A;
  logic [15:0] fifo_rdata = 16'hA1B2;
  logic fifo_empty = 1'b0, fifo_full = 1'b0;
  logic [7:0] dlo_out, dhi_out, reg_wdata;
  logic dlo_oe, dhi_oe, iocs16_pull, chrdy_pull, reg_wr, fifo_pop, fifo_push;
  logic [4:0] reg_off, reg_wr_off;
  logic [15:0] fifo_wdata;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  isa_slave_front u_isa_slave_front (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected lanes {hi, lo} from the lane map in the requirements.
  function automatic logic [1:0] exp_lanes(input int wide, input int hi_en, input int off);
    if (wide == 0) return (hi_en != 0) ? 2'b00 : 2'b01;
    if (hi_en != 0 && off == 24) return 2'b11;
    if (off % 2 == 1) return (hi_en != 0) ? 2'b10 : 2'b00;
    return (hi_en != 0) ? 2'b00 : 2'b01;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset holds everything quiet even with a strobe low on a FIFO word
    sa = 10'h2D8; sbhe_n = 1'b0; ior_n = 1'b0; fifo_empty = 1'b1;
    #1;
    chk("R12 oe in reset", {dlo_oe, dhi_oe, iocs16_pull, chrdy_pull}, 4'b0);
    @(negedge clk);
    chk("R12 pulses in reset", {reg_wr, fifo_pop, fifo_push}, 3'b0);
    ior_n = 1'b1; fifo_empty = 1'b0; sbhe_n = 1'b1;
    rst = 1'b0;
    @(negedge clk);

    // Lane sweep: reads and writes over every width, hi enable and offset
    for (int w = 0; w < 2; w++) begin
      for (int h = 0; h < 2; h++) begin
        for (int o = 0; o < 32; o++) begin
          logic [1:0] ln;
          logic word;
          ln = exp_lanes(w, h, o);
          word = (ln == 2'b11);
          sense16_n = (w == 0); sbhe_n = (h == 0);
          sa = {5'b10110, 5'(o)};
          reg_rdata = 8'(8'h11 * o + 3); fifo_rdata = 16'(16'h9C00 + o * 7);
          ior_n = 1'b0;
          #1;
          chk("R2 R3 R4 R5 R6 read lanes", {dhi_oe, dlo_oe}, ln);
          chk("R8 reg_off", reg_off, o);
          chk("R10 iocs16 on read", iocs16_pull, ln[1]);
          if (ln[0]) chk("R8 R5 lower data", dlo_out, word ? fifo_rdata[7:0] : reg_rdata);
          if (ln[1]) chk("R8 R5 upper data", dhi_out, word ? fifo_rdata[15:8] : reg_rdata);
          @(negedge clk); ior_n = 1'b1;
          @(negedge clk);
          chk("R9 pop after read", fifo_pop, word);
          // write
          dlo_in = 8'(8'h30 + o); dhi_in = 8'(8'hC0 ^ o);
          iow_n = 1'b0;
          #1;
          chk("R10 iocs16 on write", iocs16_pull, ln[1]);
          @(negedge clk); iow_n = 1'b1; dlo_in = 8'hEE; dhi_in = 8'hDD;
          @(negedge clk);
          chk("R7 R6 reg_wr", reg_wr, (ln == 2'b01 || ln == 2'b10));
          chk("R9 R6 push", fifo_push, word);
          if (ln == 2'b01 || ln == 2'b10) begin
            chk("R7 write offset", reg_wr_off, o);
            chk("R7 R2 write byte", reg_wdata, ln[1] ? (8'hC0 ^ o) : (8'h30 + o));
          end
          if (word) chk("R9 R5 push word", fifo_wdata, {8'(8'hC0 ^ o), 8'(8'h30 + o)});
          @(negedge clk);
          chk("R7 single pulse", {reg_wr, fifo_push}, 2'b00);
        end
      end
    end

    // R1: strap sweep, mismatch and address enable
    sense16_n = 1'b0; sbhe_n = 1'b1;
    for (int s = 0; s < 32; s++) begin
      base_strap = 5'(s);
      sa = {5'(s), 5'd2}; aen_n = 1'b0; ior_n = 1'b0; #1;
      chk("R1 match selects", dlo_oe, 1'b1);
      sa = {5'(s ^ 1), 5'd2}; #1;
      chk("R1 mismatch ignored", dlo_oe, 1'b0);
      sa = {5'(s), 5'd2}; aen_n = 1'b1; #1;
      chk("R1 aen_n high ignored", dlo_oe, 1'b0);
      ior_n = 1'b1; aen_n = 1'b0;
      @(negedge clk);
    end
    // R1: write to an unmatched window is dropped
    base_strap = 5'b10110; sa = 10'h0C4; iow_n = 1'b0;
    @(negedge clk); iow_n = 1'b1;
    @(negedge clk);
    chk("R1 unmatched write", reg_wr, 1'b0);
    @(negedge clk);

    // R11: blocked word read, released by data arriving
    sa = 10'h2D8; sbhe_n = 1'b0; fifo_empty = 1'b1; ior_n = 1'b0;
    @(negedge clk);
    chk("R11 wait raised", chrdy_pull, 1'b1);
    @(negedge clk); fifo_empty = 1'b0;
    @(negedge clk);
    chk("R11 released on data", chrdy_pull, 1'b0);
    ior_n = 1'b1;
    @(negedge clk); @(negedge clk);

    // R11: timeout after 64 clocks
    fifo_empty = 1'b1; ior_n = 1'b0;
    begin
      int n = 0;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (chrdy_pull) n++;
        else if (n > 0) break;
      end
      chk("R11 wait length", n, 64);
    end
    ior_n = 1'b1; fifo_empty = 1'b0;
    @(negedge clk); @(negedge clk);

    // R11: blocked word write, released when strobe rises
    fifo_full = 1'b1; iow_n = 1'b0;
    @(negedge clk);
    chk("R11 full write waits", chrdy_pull, 1'b1);
    iow_n = 1'b1;
    @(negedge clk);
    chk("R11 idle release", chrdy_pull, 1'b0);
    fifo_full = 1'b0;
    @(negedge clk);

    // R11: register read never waits
    sa = 10'h2C2; sbhe_n = 1'b1; fifo_empty = 1'b1; ior_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R11 register read no wait", chrdy_pull, 1'b0);
    ior_n = 1'b1; @(negedge clk);

    // R12: reset in the middle of a wait
    sa = 10'h2D8; sbhe_n = 1'b0; ior_n = 1'b0;
    @(negedge clk);
    chk("R12 wait before reset", chrdy_pull, 1'b1);
    rst = 1'b1; #1;
    chk("R12 reset clears wait", {chrdy_pull, dlo_oe, dhi_oe}, 3'b0);
    ior_n = 1'b1; fifo_empty = 1'b0;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule